// File: doc/BRIEF.md
# Three-Stage Pipeline Sequencing and Flush Controller

This block is the front end and sequencer of a small 32-bit processor whose pipeline has three stages: fetch, decode and execute. It holds the program counter and presents word-aligned fetch addresses to an instruction memory. A valid bit moves each instruction through decode and into execute. Decoding, operands, arithmetic and data memory are outside the block. Each instruction travels as an opaque payload next to its own address.

Execute reports control-flow changes on a redirect input. That input covers a taken branch and any write to the program counter. A redirect empties decode and fetch, and fetching restarts at the new target. A maskable interrupt request does the same thing with a vector address, but only after the executing instruction has finished. The controller then reports the address where the interrupted program has to resume. Execute also gets a program-counter read value from the block. Because fetch runs two instructions ahead, that value is the address of the executing instruction plus 8.

The instruction memory is modelled as answering in the same cycle as the request. A response-valid input lets the memory stall fetch for single cycles.

Top module: `pfc_flush_ctrl`

## Requirements
- R1: While `rst` is high, `ex_valid`, `imem_req_valid` and `irq_ack` are 0 and `imem_req_addr` is 0. The first request after reset goes to address 0, and `ex_valid` stays 0 until that instruction reaches execute, two clock edges after it was accepted.
- R2: When a request is accepted (`imem_req_valid` and `imem_rsp_valid` both high) and there is no redirect or interrupt, the next fetch address is the current one plus 4. In a cycle with `imem_rsp_valid` low, the address holds.
- R3: Bits [1:0] of `imem_req_addr` are always 0. A redirect target or vector with low bits set is fetched with those bits cleared.
- R4: An instruction accepted in cycle t appears in execute after two clock edges, with its own address on `ex_pc` and its response word on `ex_instr`. A cycle with no response becomes an execute bubble (`ex_valid` 0) two edges later.
- R5: Whenever `ex_valid` is 1, `ex_pc_read` equals `ex_pc + 8`.
- R6: A redirect (`redir_valid` with `ex_valid` high) in cycle t has three effects. The fetch address after the edge is the aligned target. `ex_valid` is 0 for the next two cycles. In the third cycle the target instruction is in execute. Nothing fetched before the redirect reaches execute.
- R7: `redir_valid` is ignored in a cycle where `ex_valid` is 0. Sequential fetch continues.
- R8: An interrupt is taken at the edge that ends any cycle in which it is pending or requested and `irq_en` is high. The executing instruction retires, and decode and fetch are discarded. After the edge, `irq_ack` is 1 for one cycle and the fetch address is the aligned `irq_vector`. `ex_valid` is 0 for two cycles, and then the vector instruction executes.
- R9: On a taken interrupt, `irq_ret_addr` holds the address of the oldest discarded instruction. This is the decode instruction's address if decode is valid, otherwise the current fetch address.
- R10: If a redirect and an interrupt occur in the same cycle, the vector is fetched and `irq_ret_addr` is the aligned redirect target.
- R11: A request raised while `irq_en` is 0 produces no `irq_ack` and does not disturb the instruction stream. It stays pending and is taken exactly once, at the first edge with `irq_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_req_valid | output | 1 | Fetch request live |
| imem_req_addr | output | AW | Word-aligned fetch address |
| imem_rsp_valid | input | 1 | Instruction word valid this cycle |
| imem_rsp_data | input | IW | Instruction word for `imem_req_addr` |
| ex_valid | output | 1 | Execute stage holds an instruction |
| ex_pc | output | AW | Address of the executing instruction |
| ex_instr | output | IW | Payload of the executing instruction |
| ex_pc_read | output | AW | Program-counter value seen by execute (`ex_pc + 8`) |
| redir_valid | input | 1 | Execute takes a branch or writes the PC |
| redir_target | input | AW | New program counter |
| irq_req | input | 1 | Interrupt request pulse |
| irq_en | input | 1 | Interrupt enable; a request waits while low |
| irq_vector | input | AW | Handler address |
| irq_ack | output | 1 | One-cycle pulse after an interrupt is taken |
| irq_ret_addr | output | AW | Address at which the interrupted program resumes |

## Verification
The properties assume three things about the inputs. The instruction word arrives in the same cycle it is requested. `irq_req` is a one-cycle pulse per event, because a level held high would be taken again on every enabled cycle. Reset is high from time zero. The redirect checks use the gated redirect, so a `redir_valid` that arrives with execute empty is allowed and is itself checked to be ignored. The stimulus drives a response word derived from the address. It drops `imem_rsp_valid` only in single deliberate stall cycles, and it pulses `irq_req` for exactly one cycle per interrupt.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int unsigned INSTR_BYTES   = 4;
  localparam int unsigned PC_READ_AHEAD = 2 * INSTR_BYTES;

  typedef enum logic [1:0] {
    NPC_HOLD  = 2'd0,
    NPC_SEQ   = 2'd1,
    NPC_REDIR = 2'd2,
    NPC_VEC   = 2'd3
  } npc_sel_e;
endpackage

// File: rtl/pfc_fetch.sv
module pfc_fetch
  import pfc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  npc_sel_e      sel,
  input  logic [AW-1:0] redir_tgt_al,
  input  logic [AW-1:0] vec_al,
  output logic          req_valid,
  output logic [AW-1:0] req_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
    end else begin
      req_valid <= 1'b1;
      unique case (sel)
        NPC_SEQ:   req_addr <= req_addr + AW'(INSTR_BYTES);
        NPC_REDIR: req_addr <= redir_tgt_al;
        NPC_VEC:   req_addr <= vec_al;
        default:   req_addr <= req_addr;
      endcase
    end
  end
endmodule

// File: rtl/pfc_stage.sv
module pfc_stage #(
  parameter int AW = 32,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [AW-1:0] in_pc,
  input  logic [IW-1:0] in_ins,
  input  logic          kill,
  output logic          out_vld,
  output logic [AW-1:0] out_pc,
  output logic [IW-1:0] out_ins
);
  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld & ~kill;
  end

  always_ff @(posedge clk) begin
    out_pc  <= in_pc;
    out_ins <= in_ins;
  end
endmodule

// File: rtl/pfc_irq.sv
module pfc_irq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_req,
  input  logic          irq_en,
  input  logic          redir,
  input  logic [AW-1:0] redir_tgt_al,
  input  logic          d_vld,
  input  logic [AW-1:0] d_pc,
  input  logic [AW-1:0] f_pc,
  output logic          take,
  output logic          ack,
  output logic [AW-1:0] ret_addr
);
  logic pend;
  logic [AW-1:0] resume_pc;

  assign take = (pend | irq_req) & irq_en;

  always_comb begin
    if (redir)      resume_pc = redir_tgt_al;
    else if (d_vld) resume_pc = d_pc;
    else            resume_pc = f_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      ack      <= 1'b0;
      ret_addr <= '0;
    end else begin
      pend <= (pend | irq_req) & ~take;
      ack  <= take;
      if (take) ret_addr <= resume_pc;
    end
  end
endmodule

// File: rtl/pfc_flush_ctrl.sv
module pfc_flush_ctrl
  import pfc_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst,
  output logic          imem_req_valid,
  output logic [AW-1:0] imem_req_addr,
  input  logic          imem_rsp_valid,
  input  logic [IW-1:0] imem_rsp_data,
  output logic          ex_valid,
  output logic [AW-1:0] ex_pc,
  output logic [IW-1:0] ex_instr,
  output logic [AW-1:0] ex_pc_read,
  input  logic          redir_valid,
  input  logic [AW-1:0] redir_target,
  input  logic          irq_req,
  input  logic          irq_en,
  input  logic [AW-1:0] irq_vector,
  output logic          irq_ack,
  output logic [AW-1:0] irq_ret_addr
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(INSTR_BYTES - 1);

  logic          redir_eff;
  logic          take;
  logic          flush;
  logic          accept;
  logic [AW-1:0] redir_tgt_al;
  logic [AW-1:0] vec_al;
  npc_sel_e      npc_sel;
  logic          d_vld;
  logic [AW-1:0] d_pc;
  logic [IW-1:0] d_ins;

  assign redir_eff    = redir_valid & ex_valid;
  assign redir_tgt_al = redir_target & ALIGN_MASK;
  assign vec_al       = irq_vector & ALIGN_MASK;
  assign accept       = imem_req_valid & imem_rsp_valid;
  assign flush        = redir_eff | take;

  always_comb begin
    if (take)           npc_sel = NPC_VEC;
    else if (redir_eff) npc_sel = NPC_REDIR;
    else if (accept)    npc_sel = NPC_SEQ;
    else                npc_sel = NPC_HOLD;
  end

  pfc_fetch #(.AW(AW)) u_fetch (
    .clk          (clk),
    .rst          (rst),
    .sel          (npc_sel),
    .redir_tgt_al (redir_tgt_al),
    .vec_al       (vec_al),
    .req_valid    (imem_req_valid),
    .req_addr     (imem_req_addr)
  );

  pfc_stage #(.AW(AW), .IW(IW)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (accept),
    .in_pc   (imem_req_addr),
    .in_ins  (imem_rsp_data),
    .kill    (flush),
    .out_vld (d_vld),
    .out_pc  (d_pc),
    .out_ins (d_ins)
  );

  pfc_stage #(.AW(AW), .IW(IW)) u_exe (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (d_vld),
    .in_pc   (d_pc),
    .in_ins  (d_ins),
    .kill    (flush),
    .out_vld (ex_valid),
    .out_pc  (ex_pc),
    .out_ins (ex_instr)
  );

  always_ff @(posedge clk) begin
    if (rst) ex_pc_read <= '0;
    else     ex_pc_read <= d_pc + AW'(PC_READ_AHEAD);
  end

  pfc_irq #(.AW(AW)) u_irq (
    .clk          (clk),
    .rst          (rst),
    .irq_req      (irq_req),
    .irq_en       (irq_en),
    .redir        (redir_eff),
    .redir_tgt_al (redir_tgt_al),
    .d_vld        (d_vld),
    .d_pc         (d_pc),
    .f_pc         (imem_req_addr),
    .take         (take),
    .ack          (irq_ack),
    .ret_addr     (irq_ret_addr)
  );
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          imem_req_valid,
  input logic [AW-1:0] imem_req_addr,
  input logic          imem_rsp_valid,
  input logic          ex_valid,
  input logic [AW-1:0] ex_pc,
  input logic [AW-1:0] ex_pc_read,
  input logic          redir_valid,
  input logic [AW-1:0] redir_target,
  input logic          irq_en,
  input logic [AW-1:0] irq_vector,
  input logic          irq_ack,
  input logic [AW-1:0] irq_ret_addr,
  input logic          redir_eff,
  input logic          take
);
  localparam logic [AW-1:0] MASK = ~AW'(3);

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!ex_valid && !imem_req_valid && !irq_ack)); // R1
  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst) (imem_req_valid && imem_rsp_valid && !redir_eff && !take) |=> imem_req_addr == $past(imem_req_addr) + AW'(4)); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst) (imem_req_valid && !imem_rsp_valid && !redir_eff && !take) |=> $stable(imem_req_addr)); // R2
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst) imem_req_valid |-> imem_req_addr[1:0] == 2'b00); // R3
  AST_PC_READ_AHEAD: assert property (@(posedge clk) disable iff (rst) ex_valid |-> ex_pc_read == ex_pc + AW'(8)); // R5
  AST_REDIR_KILL: assert property (@(posedge clk) disable iff (rst) redir_eff |=> !ex_valid); // R6
  AST_REDIR_TARGET: assert property (@(posedge clk) disable iff (rst) (redir_eff && !take) |=> imem_req_addr == ($past(redir_target) & MASK)); // R6
  AST_REDIR_IGNORED: assert property (@(posedge clk) disable iff (rst) (!ex_valid && redir_valid && !take && imem_req_valid && imem_rsp_valid) |=> imem_req_addr == $past(imem_req_addr) + AW'(4)); // R7
  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (rst) take |=> (irq_ack && !ex_valid && imem_req_addr == ($past(irq_vector) & MASK))); // R8
  AST_BOTH_RETURN: assert property (@(posedge clk) disable iff (rst) (take && redir_eff) |=> irq_ret_addr == ($past(redir_target) & MASK)); // R10
  AST_MASKED_NO_ACK: assert property (@(posedge clk) disable iff (rst) !irq_en |=> !irq_ack); // R11
endmodule

bind pfc_flush_ctrl pfc_checker #(.AW(AW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .imem_req_valid (imem_req_valid),
  .imem_req_addr  (imem_req_addr),
  .imem_rsp_valid (imem_rsp_valid),
  .ex_valid       (ex_valid),
  .ex_pc          (ex_pc),
  .ex_pc_read     (ex_pc_read),
  .redir_valid    (redir_valid),
  .redir_target   (redir_target),
  .irq_en         (irq_en),
  .irq_vector     (irq_vector),
  .irq_ack        (irq_ack),
  .irq_ret_addr   (irq_ret_addr),
  .redir_eff      (redir_eff),
  .take           (take)
);

// File: tb/pfc_flush_ctrl_tb.sv
module pfc_flush_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int IW = 32;
  localparam int NTAB = 4;
  // {redirect target, expected aligned fetch address}
  localparam logic [63:0] REDIR_TAB [NTAB] = '{
    {32'h0000_0100, 32'h0000_0100},
    {32'h0000_0203, 32'h0000_0200},
    {32'h0000_1001, 32'h0000_1000},
    {32'hFFFF_FFFE, 32'hFFFF_FFFC}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          imem_req_valid;
  logic [AW-1:0] imem_req_addr;
  logic          imem_rsp_valid;
  logic [IW-1:0] imem_rsp_data;
  logic          ex_valid;
  logic [AW-1:0] ex_pc;
  logic [IW-1:0] ex_instr;
  logic [AW-1:0] ex_pc_read;
  logic          redir_valid;
  logic [AW-1:0] redir_target;
  logic          irq_req;
  logic          irq_en;
  logic [AW-1:0] irq_vector;
  logic          irq_ack;
  logic [AW-1:0] irq_ret_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // instruction memory model: word derived from its address, same-cycle answer
  assign imem_rsp_data = ~imem_req_addr;

  pfc_flush_ctrl #(.AW(AW), .IW(IW)) u_dut (
    .clk (clk), .rst (rst),
    .imem_req_valid (imem_req_valid), .imem_req_addr (imem_req_addr),
    .imem_rsp_valid (imem_rsp_valid), .imem_rsp_data (imem_rsp_data),
    .ex_valid (ex_valid), .ex_pc (ex_pc), .ex_instr (ex_instr), .ex_pc_read (ex_pc_read),
    .redir_valid (redir_valid), .redir_target (redir_target),
    .irq_req (irq_req), .irq_en (irq_en), .irq_vector (irq_vector),
    .irq_ack (irq_ack), .irq_ret_addr (irq_ret_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // advance one edge, sample away from it, run the per-cycle checks
  task automatic step();
    @(posedge clk);
    #1;
    if (!rst) begin
      chk("R3 fetch address low bits", {30'd0, imem_req_addr[1:0]}, 32'd0);
      if (ex_valid) begin
        chk("R5 pc read ahead", ex_pc_read, ex_pc + 32'd8);
        chk("R4 payload follows address", ex_instr, ~ex_pc);
      end
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; imem_rsp_valid = 1'b1; redir_valid = 1'b0; redir_target = '0;
    irq_req = 1'b0; irq_en = 1'b0; irq_vector = '0;
    repeat (3) step();
    chk("R1 ex_valid in reset", {31'd0, ex_valid}, 32'd0);
    chk("R1 req_valid in reset", {31'd0, imem_req_valid}, 32'd0);
    chk("R1 ack in reset", {31'd0, irq_ack}, 32'd0);
    chk("R1 addr in reset", imem_req_addr, 32'd0);

    rst = 1'b0;
    step();
    chk("R1 first request valid", {31'd0, imem_req_valid}, 32'd1);
    chk("R1 first request address", imem_req_addr, 32'd0);
    step();
    chk("R2 sequential address", imem_req_addr, 32'd4);
    chk("R1 nothing executes before refill", {31'd0, ex_valid}, 32'd0);
    step();
    chk("R4 first instr in execute", {31'd0, ex_valid}, 32'd1);
    chk("R4 first instr address", ex_pc, 32'd0);
    chk("R5 first pc read", ex_pc_read, 32'd8);
    step();
    chk("R4 second instr", ex_pc, 32'd4);
    chk("R2 sequential address", imem_req_addr, 32'd12);

    // stall one cycle
    imem_rsp_valid = 1'b0;
    step();
    imem_rsp_valid = 1'b1;
    chk("R2 address held on stall", imem_req_addr, 32'd12);
    chk("R4 stream before bubble", ex_pc, 32'd8);
    step();
    chk("R4 stall bubble in execute", {31'd0, ex_valid}, 32'd0);
    chk("R2 advance after stall", imem_req_addr, 32'd16);
    step();
    chk("R4 after bubble", ex_pc, 32'd12);

    // table-driven redirects
    for (int i = 0; i < NTAB; i++) begin
      logic [31:0] tgt;
      logic [31:0] exp;
      tgt = REDIR_TAB[i][63:32];
      exp = REDIR_TAB[i][31:0];
      chk("R6 execute busy before redirect", {31'd0, ex_valid}, 32'd1);
      redir_valid = 1'b1; redir_target = tgt;
      step();
      redir_valid = 1'b0;
      chk("R6 R3 aligned target fetched", imem_req_addr, exp);
      chk("R6 first flush cycle", {31'd0, ex_valid}, 32'd0);
      step();
      chk("R6 second flush cycle", {31'd0, ex_valid}, 32'd0);
      chk("R6 fetch after target", imem_req_addr, exp + 32'd4);
      step();
      chk("R6 target executes", {31'd0, ex_valid}, 32'd1);
      chk("R6 target address", ex_pc, exp);
      chk("R5 pc read at target", ex_pc_read, exp + 32'd8);
      step();
    end

    // redirect with empty execute is ignored
    redir_valid = 1'b1; redir_target = 32'h400;
    step();
    redir_target = 32'h800;
    chk("R7 execute empty", {31'd0, ex_valid}, 32'd0);
    step();
    redir_valid = 1'b0;
    chk("R7 ignored redirect", imem_req_addr, 32'h404);
    step();
    chk("R7 original target executes", ex_pc, 32'h400);
    step();
    chk("R7 stream continues", ex_pc, 32'h404);

    // interrupt with decode valid
    irq_en = 1'b1; irq_vector = 32'h2002; irq_req = 1'b1;
    step();
    irq_req = 1'b0;
    chk("R8 ack", {31'd0, irq_ack}, 32'd1);
    chk("R9 return is decode instr", irq_ret_addr, 32'h408);
    chk("R8 vector fetched", imem_req_addr, 32'h2000);
    chk("R8 execute flushed", {31'd0, ex_valid}, 32'd0);
    step();
    chk("R8 ack single cycle", {31'd0, irq_ack}, 32'd0);
    chk("R8 still flushed", {31'd0, ex_valid}, 32'd0);
    step();
    chk("R8 vector executes", ex_pc, 32'h2000);

    // interrupt while decode is empty
    redir_valid = 1'b1; redir_target = 32'h3000;
    step();
    redir_valid = 1'b0;
    irq_req = 1'b1;
    step();
    irq_req = 1'b0;
    chk("R8 ack after refill start", {31'd0, irq_ack}, 32'd1);
    chk("R9 return is fetch address", irq_ret_addr, 32'h3000);
    chk("R8 vector fetched again", imem_req_addr, 32'h2000);
    step();
    step();
    chk("R8 vector executes again", ex_pc, 32'h2000);
    step();

    // redirect and interrupt together
    redir_valid = 1'b1; redir_target = 32'h5005; irq_req = 1'b1;
    step();
    redir_valid = 1'b0; irq_req = 1'b0;
    chk("R10 ack", {31'd0, irq_ack}, 32'd1);
    chk("R10 return is redirect target", irq_ret_addr, 32'h5004);
    chk("R10 vector wins fetch", imem_req_addr, 32'h2000);
    step();
    step();
    chk("R10 vector executes", ex_pc, 32'h2000);

    // masked request
    irq_en = 1'b0; irq_req = 1'b1;
    step();
    irq_req = 1'b0;
    chk("R11 no ack while masked", {31'd0, irq_ack}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R11 no ack while masked", {31'd0, irq_ack}, 32'd0);
      chk("R11 stream undisturbed", {31'd0, ex_valid}, 32'd1);
    end
    irq_vector = 32'h6000; irq_en = 1'b1;
    step();
    chk("R11 pending taken on enable", {31'd0, irq_ack}, 32'd1);
    chk("R11 vector fetched", imem_req_addr, 32'h6000);
    step();
    chk("R11 taken once", {31'd0, irq_ack}, 32'd0);
    step();
    chk("R11 no repeat", {31'd0, irq_ack}, 32'd0);

    done = 1'b1;
    finish_run();
  end
endmodule